// File: doc/BRIEF.md
# Fan Control Configuration Lock Register

This block is the control register of a fan-control subsystem together with the bank of limit and parameter registers that it guards. Four control flags sit in one byte. The first flag chooses whether the fan controller works from the programmed parameter bank or from a built-in default set. The second flag is a write-once lock that freezes the parameter bank. The third flag is a status flag that reports power-up completion. The fourth flag forces every PWM duty output to full scale.

Software programs the parameter bank through a simple write/read register port. It then sets the start flag so that the controller uses the programmed values, and it may set the lock flag to make the bank read-only until the next power-on reset. The PWM generators supply their requested duty and a per-channel disable flag. The block returns the final duty, with the override applied last.

Top module: `fan_cfg_lock`

## Requirements
- R1: After power-on reset (`rst_n` low), the control byte reads 0x00, every parameter register reads 0x00, and `active_param` carries the default set.
- R2: The control byte at address 0 has this layout: bit 0 is start, bit 1 is lock, bit 2 is ready and bit 3 is override. Bits 7..4 always read 0, and writes to them are ignored.
- R3: While start is 0, slot i of `active_param` (bits i*8+7..i*8) equals the default 0x40 + i*0x10. While start is 1, it equals the stored parameter register i.
- R4: Changing start never alters the values held in the parameter registers.
- R5: Once lock is 1, writing 0 to it has no effect. Only `rst_n` clears it.
- R6: Parameter register i sits at address i+1. While unlocked, a write stores the data, and the new value reads back from the next cycle on. While locked, a write is dropped and the old value still reads back.
- R7: Start and override remain writable while lock is 1.
- R8: Ready becomes 1 on the clock edge after `pwr_done` and `conv_ready` are both high. It then stays 1 until reset, and writes to bit 2 are ignored.
- R9: While override is 1, every channel of `pwm_duty_out` is 0xFF, whether or not the channel is disabled and whatever the lock state.
- R10: While override is 0, a disabled channel outputs 0x00 and an enabled channel passes its `pwm_duty_in` slot through unchanged.
- R11: Addresses above the parameter bank read 0x00, and writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low power-on reset, asynchronous |
| bus_we | input | 1 | Write strobe for the register port |
| bus_addr | input | 4 | Register address: 0 is the control byte, 1..6 are the parameters |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr`, combinational |
| pwr_done | input | 1 | Power-up reset sequence has completed |
| conv_ready | input | 1 | Converters report ready |
| active_param | output | 48 | Parameter set in use, slot i at bits i*8+7..i*8 |
| pwm_duty_in | input | 24 | Requested duty per channel, channel k at bits k*8+7..k*8 |
| pwm_dis | input | 3 | Per-channel disable |
| pwm_duty_out | output | 24 | Final duty per channel |

## Verification
The assertions check the per-cycle invariants on every cycle. Lock and ready never fall outside reset, the parameter bank holds still on any cycle that follows a locked one, and override forces full scale on every channel. They also check that a disabled channel reads zero without override, that `active_param` follows start, and that the reserved bits read zero. Other behaviours can only be shown by the bench's scenarios, because they depend on a chosen sequence of writes: a value stored before locking survives start toggles, a locked write is dropped while start and override still take effect, a write to an unmapped address is ignored, and reset restores the defaults.

// File: rtl/fcl_pkg.sv
package fcl_pkg;

    // Bit positions inside the control byte; software decodes these.
    localparam int unsigned START_BIT = 0;
    localparam int unsigned LOCK_BIT  = 1;
    localparam int unsigned READY_BIT = 2;
    localparam int unsigned OVR_BIT   = 3;
    localparam int unsigned CTRL_BITS = 4;

    typedef struct packed {
        logic ovr;
        logic ready;
        logic lock;
        logic start;
    } ctrl_t;

endpackage

// File: rtl/fcl_ctrl_reg.sv
module fcl_ctrl_reg
    import fcl_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  wr_ctrl,
    input  logic  wr_start,
    input  logic  wr_lock,
    input  logic  wr_ovr,
    input  logic  pwr_ok,
    output ctrl_t ctrl_q
);

    typedef struct packed {
        ctrl_t bits;
    } state_t;

    state_t st_d;
    state_t st_q;

    always_comb begin
        st_d = st_q;
        if (pwr_ok) begin
            st_d.bits.ready = 1'b1;
        end
        if (wr_ctrl) begin
            st_d.bits.start = wr_start;
            st_d.bits.ovr   = wr_ovr;
            // lock can only be raised; a set lock ignores further writes
            st_d.bits.lock  = st_q.bits.lock | wr_lock;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign ctrl_q = st_q.bits;

endmodule

// File: rtl/fcl_param_bank.sv
module fcl_param_bank #(
    parameter int unsigned N_PARAM = 6,
    parameter int unsigned DW      = 8,
    parameter int unsigned AW      = 4
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    lock,
    input  logic                    we,
    input  logic [AW-1:0]           addr,
    input  logic [DW-1:0]           wdata,
    output logic [N_PARAM*DW-1:0]   store_flat
);

    typedef struct packed {
        logic [N_PARAM-1:0][DW-1:0] val;
    } bank_t;

    bank_t st_d;
    bank_t st_q;
    logic [N_PARAM-1:0] hit;

    for (genvar i = 0; i < N_PARAM; i++) begin : g_dec
        localparam logic [AW-1:0] SLOT_ADDR = AW'(i + 1);
        assign hit[i] = we && !lock && (addr == SLOT_ADDR);
    end

    always_comb begin
        st_d = st_q;
        for (int i = 0; i < N_PARAM; i++) begin
            if (hit[i]) begin
                st_d.val[i] = wdata;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign store_flat = st_q.val;

endmodule

// File: rtl/fcl_param_sel.sv
module fcl_param_sel #(
    parameter int unsigned N_PARAM  = 6,
    parameter int unsigned DW       = 8,
    parameter int unsigned DEF_BASE = 'h40,
    parameter int unsigned DEF_STEP = 'h10
) (
    input  logic                  start,
    input  logic [N_PARAM*DW-1:0] store_flat,
    output logic [N_PARAM*DW-1:0] active_flat
);

    for (genvar i = 0; i < N_PARAM; i++) begin : g_slot
        localparam logic [DW-1:0] DEF_VAL = DW'(DEF_BASE + i * DEF_STEP);
        assign active_flat[i*DW +: DW] = start ? store_flat[i*DW +: DW] : DEF_VAL;
    end

endmodule

// File: rtl/fcl_duty_mux.sv
module fcl_duty_mux #(
    parameter int unsigned N_PWM = 3,
    parameter int unsigned DW    = 8
) (
    input  logic                ovr,
    input  logic [N_PWM-1:0]    dis,
    input  logic [N_PWM*DW-1:0] duty_in,
    output logic [N_PWM*DW-1:0] duty_out
);

    localparam logic [DW-1:0] FULL = '1;

    for (genvar k = 0; k < N_PWM; k++) begin : g_ch
        logic [DW-1:0] gated;
        assign gated = dis[k] ? '0 : duty_in[k*DW +: DW];
        // override applied last, above the disable path
        assign duty_out[k*DW +: DW] = ovr ? FULL : gated;
    end

endmodule

// File: rtl/fan_cfg_lock.sv
module fan_cfg_lock
    import fcl_pkg::*;
#(
    parameter int unsigned N_PARAM  = 6,
    parameter int unsigned N_PWM    = 3,
    parameter int unsigned DW       = 8,
    parameter int unsigned AW       = 4,
    parameter int unsigned DEF_BASE = 'h40,
    parameter int unsigned DEF_STEP = 'h10
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  bus_we,
    input  logic [AW-1:0]         bus_addr,
    input  logic [DW-1:0]         bus_wdata,
    output logic [DW-1:0]         bus_rdata,
    input  logic                  pwr_done,
    input  logic                  conv_ready,
    output logic [N_PARAM*DW-1:0] active_param,
    input  logic [N_PWM*DW-1:0]   pwm_duty_in,
    input  logic [N_PWM-1:0]      pwm_dis,
    output logic [N_PWM*DW-1:0]   pwm_duty_out
);

    localparam logic [AW-1:0] CTRL_ADDR = '0;

    ctrl_t                 ctrl;
    logic                  wr_ctrl;
    logic [N_PARAM*DW-1:0] store_flat;

    assign wr_ctrl = bus_we && (bus_addr == CTRL_ADDR);

    fcl_ctrl_reg u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_ctrl  (wr_ctrl),
        .wr_start (bus_wdata[START_BIT]),
        .wr_lock  (bus_wdata[LOCK_BIT]),
        .wr_ovr   (bus_wdata[OVR_BIT]),
        .pwr_ok   (pwr_done & conv_ready),
        .ctrl_q   (ctrl)
    );

    fcl_param_bank #(
        .N_PARAM (N_PARAM),
        .DW      (DW),
        .AW      (AW)
    ) u_bank (
        .clk        (clk),
        .rst_n      (rst_n),
        .lock       (ctrl.lock),
        .we         (bus_we),
        .addr       (bus_addr),
        .wdata      (bus_wdata),
        .store_flat (store_flat)
    );

    fcl_param_sel #(
        .N_PARAM  (N_PARAM),
        .DW       (DW),
        .DEF_BASE (DEF_BASE),
        .DEF_STEP (DEF_STEP)
    ) u_sel (
        .start       (ctrl.start),
        .store_flat  (store_flat),
        .active_flat (active_param)
    );

    fcl_duty_mux #(
        .N_PWM (N_PWM),
        .DW    (DW)
    ) u_duty (
        .ovr      (ctrl.ovr),
        .dis      (pwm_dis),
        .duty_in  (pwm_duty_in),
        .duty_out (pwm_duty_out)
    );

    always_comb begin
        bus_rdata = '0;
        if (bus_addr == CTRL_ADDR) begin
            bus_rdata[START_BIT] = ctrl.start;
            bus_rdata[LOCK_BIT]  = ctrl.lock;
            bus_rdata[READY_BIT] = ctrl.ready;
            bus_rdata[OVR_BIT]   = ctrl.ovr;
        end
        for (int i = 0; i < N_PARAM; i++) begin
            if (bus_addr == AW'(i + 1)) begin
                bus_rdata = store_flat[i*DW +: DW];
            end
        end
    end

endmodule

// File: rtl/fcl_checker.sv
module fcl_checker #(
    parameter int unsigned N_PARAM  = 6,
    parameter int unsigned N_PWM    = 3,
    parameter int unsigned DW       = 8,
    parameter int unsigned AW       = 4,
    parameter int unsigned DEF_BASE = 'h40,
    parameter int unsigned DEF_STEP = 'h10
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  start,
    input logic                  lock,
    input logic                  ready,
    input logic                  ovr,
    input logic                  pwr_done,
    input logic                  conv_ready,
    input logic [AW-1:0]         bus_addr,
    input logic [DW-1:0]         bus_rdata,
    input logic [N_PARAM*DW-1:0] store_flat,
    input logic [N_PARAM*DW-1:0] active_param,
    input logic [N_PWM-1:0]      pwm_dis,
    input logic [N_PWM*DW-1:0]   pwm_duty_out
);

    AST_LOCK_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        lock |=> lock) else $error("lock fell"); // R5

    AST_BANK_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        lock |=> $stable(store_flat)) else $error("locked bank changed"); // R6

    AST_READY_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        ready |=> ready) else $error("ready fell"); // R8

    AST_READY_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (pwr_done && conv_ready) |=> ready) else $error("ready not set"); // R8

    AST_OVR_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        ovr |-> (pwm_duty_out == '1)) else $error("override not full"); // R9

    AST_RSV_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == '0) |-> (bus_rdata[DW-1:4] == '0)) else $error("reserved set"); // R2

    AST_START_PROG: assert property (@(posedge clk) disable iff (!rst_n)
        start |-> (active_param == store_flat)) else $error("programmed set not used"); // R3

    for (genvar i = 0; i < N_PARAM; i++) begin : g_def
        AST_DEFAULT_SEL: assert property (@(posedge clk) disable iff (!rst_n)
            !start |-> (active_param[i*DW +: DW] == DW'(DEF_BASE + i * DEF_STEP)))
            else $error("default not used"); // R3
    end

    for (genvar k = 0; k < N_PWM; k++) begin : g_dis
        AST_DIS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
            (!ovr && pwm_dis[k]) |-> (pwm_duty_out[k*DW +: DW] == '0))
            else $error("disabled channel not zero"); // R10
    end

endmodule

bind fan_cfg_lock fcl_checker #(
    .N_PARAM  (N_PARAM),
    .N_PWM    (N_PWM),
    .DW       (DW),
    .AW       (AW),
    .DEF_BASE (DEF_BASE),
    .DEF_STEP (DEF_STEP)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .start        (ctrl.start),
    .lock         (ctrl.lock),
    .ready        (ctrl.ready),
    .ovr          (ctrl.ovr),
    .pwr_done     (pwr_done),
    .conv_ready   (conv_ready),
    .bus_addr     (bus_addr),
    .bus_rdata    (bus_rdata),
    .store_flat   (store_flat),
    .active_param (active_param),
    .pwm_dis      (pwm_dis),
    .pwm_duty_out (pwm_duty_out)
);

// File: tb/tb_fan_cfg_lock.sv
module tb_fan_cfg_lock;

    localparam int NP = 6;
    localparam int NC = 3;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          bus_we = 1'b0;
    logic [3:0]    bus_addr = '0;
    logic [7:0]    bus_wdata = '0;
    logic [7:0]    bus_rdata;
    logic          pwr_done = 1'b0;
    logic          conv_ready = 1'b0;
    logic [NP*8-1:0] active_param;
    logic [NC*8-1:0] pwm_duty_in = '0;
    logic [NC-1:0]   pwm_dis = '0;
    logic [NC*8-1:0] pwm_duty_out;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    fan_cfg_lock dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .bus_we       (bus_we),
        .bus_addr     (bus_addr),
        .bus_wdata    (bus_wdata),
        .bus_rdata    (bus_rdata),
        .pwr_done     (pwr_done),
        .conv_ready   (conv_ready),
        .active_param (active_param),
        .pwm_duty_in  (pwm_duty_in),
        .pwm_dis      (pwm_dis),
        .pwm_duty_out (pwm_duty_out)
    );

    typedef struct packed {
        logic       we;
        logic [3:0] addr;
        logic [7:0] wdata;
        logic [7:0] exp;
    } vec_t;

    // Each entry: optional write, then read the same address and compare.
    localparam vec_t TBL [7] = '{
        '{1'b1, 4'd1, 8'h5A, 8'h5A},   // R6 unlocked store
        '{1'b1, 4'd6, 8'hC3, 8'hC3},   // R6 last slot
        '{1'b1, 4'd0, 8'hF1, 8'h01},   // R2 reserved ignored, start set
        '{1'b0, 4'd1, 8'h00, 8'h5A},   // R4 value kept after start change
        '{1'b1, 4'd0, 8'h00, 8'h00},   // R2 start cleared
        '{1'b1, 4'd7, 8'hFF, 8'h00},   // R11 unmapped reads 0
        '{1'b0, 4'd6, 8'h00, 8'hC3}    // R11 unmapped write left slot alone
    };

    task automatic chk8(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual 0x%02h expected 0x%02h", tag, act, exp);
        end
    endtask

    task automatic bus_write(input logic [3:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic read_chk(input string tag, input logic [3:0] a, input logic [7:0] exp);
        bus_addr = a;
        #1;
        chk8(tag, bus_rdata, exp);
    endtask

    task automatic chk_defaults(input string tag);
        for (int i = 0; i < NP; i++) begin
            chk8(tag, active_param[i*8 +: 8], 8'(8'h40 + i * 8'h10));
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        read_chk("R1 ctrl", 4'd0, 8'h00);
        for (int i = 1; i <= NP; i++) read_chk("R1 param", 4'(i), 8'h00);
        chk_defaults("R1 defaults");

        // vector table
        for (int v = 0; v < 7; v++) begin
            if (TBL[v].we) bus_write(TBL[v].addr, TBL[v].wdata);
            else @(negedge clk);
            read_chk("R2/R4/R6/R11 vector", TBL[v].addr, TBL[v].exp);
        end

        // R3 selection by start
        chk_defaults("R3 start=0");
        bus_write(4'd0, 8'h01);
        #1;
        chk8("R3 start=1 slot0", active_param[7:0], 8'h5A);
        chk8("R3 start=1 slot5", active_param[47:40], 8'hC3);
        chk8("R3 start=1 slot1", active_param[15:8], 8'h00);
        bus_write(4'd0, 8'h00);
        #1;
        chk_defaults("R3 start back to 0");
        read_chk("R4 slot0 kept", 4'd1, 8'h5A);

        // R10 disable path
        pwm_duty_in = {8'hC0, 8'h80, 8'h20};
        pwm_dis = 3'b010;
        #1;
        chk8("R10 ch0", pwm_duty_out[7:0], 8'h20);
        chk8("R10 ch1 disabled", pwm_duty_out[15:8], 8'h00);
        chk8("R10 ch2", pwm_duty_out[23:16], 8'hC0);

        // R9 override
        bus_write(4'd0, 8'h08);
        #1;
        for (int k = 0; k < NC; k++) chk8("R9 override full", pwm_duty_out[k*8 +: 8], 8'hFF);
        bus_write(4'd0, 8'h00);
        #1;
        chk8("R10 after override off", pwm_duty_out[15:8], 8'h00);

        // R8 ready
        pwr_done = 1'b1;
        @(negedge clk); @(negedge clk);
        read_chk("R8 one input only", 4'd0, 8'h00);
        conv_ready = 1'b1;
        @(negedge clk);
        read_chk("R8 ready set", 4'd0, 8'h04);
        pwr_done = 1'b0; conv_ready = 1'b0;
        @(negedge clk);
        read_chk("R8 ready sticky", 4'd0, 8'h04);
        bus_write(4'd0, 8'h00);
        read_chk("R8 write ignored", 4'd0, 8'h04);

        // R5/R6/R7 lock
        bus_write(4'd0, 8'h03);
        read_chk("R5 lock set", 4'd0, 8'h07);
        bus_write(4'd1, 8'h11);
        read_chk("R6 locked write dropped", 4'd1, 8'h5A);
        bus_write(4'd3, 8'h77);
        read_chk("R6 locked slot2", 4'd3, 8'h00);
        #1;
        chk8("R3 locked start=1", active_param[7:0], 8'h5A);
        bus_write(4'd0, 8'h00);
        read_chk("R5/R7 lock stays start clears", 4'd0, 8'h06);
        bus_write(4'd0, 8'h09);
        read_chk("R7 start+override while locked", 4'd0, 8'h0F);
        #1;
        chk8("R9 override while locked", pwm_duty_out[15:8], 8'hFF);

        // R1 reset clears lock
        @(negedge clk);
        rst_n = 1'b0;
        #1;
        read_chk("R1 ctrl after reset", 4'd0, 8'h00);
        read_chk("R1 param after reset", 4'd1, 8'h00);
        chk_defaults("R1 defaults after reset");
        @(negedge clk);
        rst_n = 1'b1;
        bus_write(4'd2, 8'h3C);
        read_chk("R5 unlocked after reset", 4'd2, 8'h3C);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule